// File: doc/BRIEF.md
# Seconds Counter with Alarm

This block is the time base of a battery-backed real-time clock. A count of whole seconds sits above a binary fraction of a second, and the pair advances by one on every pulse of a 32.768 kHz tick strobe. Software can load either word on its own and read both back. One fraction word spans exactly one second, so the fraction carries into the seconds word each time it passes its top value.

The count moves only when several conditions agree. It needs the enable input high, no halt request from the security monitor (a non-valid or failed unit), and a clear overflow flag. When the full count would wrap past all-ones, the block stops instead: it raises a sticky overflow flag and keeps the count at all-ones until software clears the flag. Either of two lock inputs blocks writes to the count.

A seconds-only alarm register, reset to all-ones, is compared against the seconds word. When the seconds word starts to equal it, the block raises a sticky alarm flag. Software clears the flag by writing one to its clear strobe. An interrupt output gates the flag with an enable input.

Top module: `rtc_sec_counter`

## Requirements
- R1: After reset the seconds word is 0, the fraction word is 0, the alarm word is all-ones (32'hFFFF_FFFF), and the alarm flag, overflow flag and alarm interrupt are 0.
- R2: A seconds write loads wdata_i into the seconds word. A fraction write loads wdata_i[14:0] into the fraction word, and the upper data bits are ignored. The new value is visible the cycle after the write.
- R3: While counting is allowed, each tick_i pulse adds one to the 47-bit count {seconds, fraction}. A fraction of 15'h7FFF rolls to 0 and the seconds word goes up by one.
- R4: While cnt_en_i is low, tick_i pulses leave the count unchanged.
- R5: While halt_i is high, tick_i pulses leave the count unchanged.
- R6: While lock_soft_i or lock_hard_i is high, seconds and fraction writes are ignored and the count keeps its value.
- R7: The alarm word is written by alm_we_i. The alarm flag sets one cycle after the seconds word becomes equal to the alarm word. This holds whether the seconds word got there by counting or by a write.
- R8: A pulse on alm_clr_i clears the alarm flag. The flag stays clear while the seconds word keeps matching the alarm word; it sets again only on a new arrival at the match.
- R9: alm_irq_o is high exactly when the alarm flag and alm_ie_i are both high.
- R10: A tick that would take the count past all-ones sets the overflow flag and leaves the count at all-ones.
- R11: While the overflow flag is set, ticks leave the count unchanged; writes to the count still load. A pulse on ovf_clr_i clears the flag, and counting resumes on later ticks.
- R12: A permitted count write in the same cycle as a tick wins. The written value is loaded and the count is not incremented in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 32.768 kHz advance strobe, one cycle wide |
| cnt_en_i | input | 1 | Counter enable |
| halt_i | input | 1 | Stop request from the security monitor |
| lock_soft_i | input | 1 | Soft lock on count writes |
| lock_hard_i | input | 1 | Hard lock on count writes |
| sec_we_i | input | 1 | Seconds word write strobe |
| frac_we_i | input | 1 | Fraction word write strobe |
| alm_we_i | input | 1 | Alarm word write strobe |
| wdata_i | input | 32 | Write data |
| alm_clr_i | input | 1 | Write-one-to-clear for the alarm flag |
| ovf_clr_i | input | 1 | Write-one-to-clear for the overflow flag |
| alm_ie_i | input | 1 | Alarm interrupt enable |
| sec_o | output | 32 | Seconds word |
| frac_o | output | 15 | Fraction word |
| alm_o | output | 32 | Alarm word |
| alm_flag_o | output | 1 | Alarm flag |
| ovf_flag_o | output | 1 | Overflow flag |
| alm_irq_o | output | 1 | Alarm interrupt |

## Verification
The overflow condition is the hardest to reach from the ports. Counting up to all-ones from zero would take about 2^47 ticks. The stimulus instead writes all-ones into both words and then sends a single tick. It then holds the flag set, rewrites the count, and checks that ticks still do nothing until the clear strobe, after which the count moves again. The alarm is brought to a match the same short way: the fraction is preloaded with 15'h7FFF so that one tick carries into the seconds word.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_LOAD = 2'd1,
    CNT_STEP = 2'd2,
    CNT_SAT  = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/rtc_cnt_ctrl.sv
module rtc_cnt_ctrl
  import rtc_pkg::*;
(
  input  logic    tick_i,
  input  logic    cnt_en_i,
  input  logic    halt_i,
  input  logic    lock_soft_i,
  input  logic    lock_hard_i,
  input  logic    sec_we_i,
  input  logic    frac_we_i,
  input  logic    ovf_flag_i,
  input  logic    at_max_i,
  output logic    ld_sec_o,
  output logic    ld_frac_o,
  output cnt_op_e op_o
);
  logic locked;
  logic run;

  assign locked    = lock_soft_i | lock_hard_i;
  assign ld_sec_o  = sec_we_i & ~locked;
  assign ld_frac_o = frac_we_i & ~locked;
  assign run       = tick_i & cnt_en_i & ~halt_i & ~ovf_flag_i;

  always_comb begin
    if (ld_sec_o || ld_frac_o) op_o = CNT_LOAD;   // load beats the tick
    else if (run)              op_o = at_max_i ? CNT_SAT : CNT_STEP;
    else                       op_o = CNT_HOLD;
  end
endmodule

// File: rtl/rtc_cnt_core.sv
module rtc_cnt_core
  import rtc_pkg::*;
#(
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned FRAC_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cnt_op_e           op_i,
  input  logic              ld_sec_i,
  input  logic              ld_frac_i,
  input  logic [SEC_W-1:0]  wdata_i,
  input  logic              ovf_clr_i,
  output logic [SEC_W-1:0]  sec_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic              ovf_flag_o,
  output logic              at_max_o
);
  localparam int unsigned CNT_W = SEC_W + FRAC_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             ovf_q;

  assign cnt_inc  = cnt_q + CNT_W'(1);
  assign at_max_o = &cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      unique case (op_i)
        CNT_LOAD: begin
          if (ld_sec_i)  cnt_q[CNT_W-1:FRAC_W] <= wdata_i;
          if (ld_frac_i) cnt_q[FRAC_W-1:0]     <= wdata_i[FRAC_W-1:0];
        end
        CNT_STEP: cnt_q <= cnt_inc;
        default:  cnt_q <= cnt_q;  // hold, or saturate at all-ones
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ovf_q <= 1'b0;
    else if (op_i == CNT_SAT) ovf_q <= 1'b1;
    else if (ovf_clr_i)       ovf_q <= 1'b0;
  end

  assign sec_o      = cnt_q[CNT_W-1:FRAC_W];
  assign frac_o     = cnt_q[FRAC_W-1:0];
  assign ovf_flag_o = ovf_q;
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter int unsigned SEC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alm_we_i,
  input  logic [SEC_W-1:0] wdata_i,
  input  logic [SEC_W-1:0] sec_i,
  input  logic             alm_clr_i,
  input  logic             alm_ie_i,
  output logic [SEC_W-1:0] alm_o,
  output logic             alm_flag_o,
  output logic             alm_irq_o
);
  logic [SEC_W-1:0] alm_q;
  logic             hit;
  logic             hit_q;
  logic             flag_q;

  assign hit = (sec_i == alm_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_q <= '1;
      hit_q <= 1'b0;
    end else begin
      if (alm_we_i) alm_q <= wdata_i;
      hit_q <= hit;
    end
  end

  // set only on arrival at the match, so a clear is not undone
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             flag_q <= 1'b0;
    else if (hit && !hit_q)  flag_q <= 1'b1;
    else if (alm_clr_i)      flag_q <= 1'b0;
  end

  assign alm_o      = alm_q;
  assign alm_flag_o = flag_q;
  assign alm_irq_o  = flag_q & alm_ie_i;
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter
  import rtc_pkg::*;
#(
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned FRAC_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cnt_en_i,
  input  logic              halt_i,
  input  logic              lock_soft_i,
  input  logic              lock_hard_i,
  input  logic              sec_we_i,
  input  logic              frac_we_i,
  input  logic              alm_we_i,
  input  logic [SEC_W-1:0]  wdata_i,
  input  logic              alm_clr_i,
  input  logic              ovf_clr_i,
  input  logic              alm_ie_i,
  output logic [SEC_W-1:0]  sec_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic [SEC_W-1:0]  alm_o,
  output logic              alm_flag_o,
  output logic              ovf_flag_o,
  output logic              alm_irq_o
);
  cnt_op_e cnt_op;
  logic    ld_sec;
  logic    ld_frac;
  logic    at_max;

  rtc_cnt_ctrl i_ctrl (
    .tick_i      (tick_i),
    .cnt_en_i    (cnt_en_i),
    .halt_i      (halt_i),
    .lock_soft_i (lock_soft_i),
    .lock_hard_i (lock_hard_i),
    .sec_we_i    (sec_we_i),
    .frac_we_i   (frac_we_i),
    .ovf_flag_i  (ovf_flag_o),
    .at_max_i    (at_max),
    .ld_sec_o    (ld_sec),
    .ld_frac_o   (ld_frac),
    .op_o        (cnt_op)
  );

  rtc_cnt_core #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) i_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (cnt_op),
    .ld_sec_i   (ld_sec),
    .ld_frac_i  (ld_frac),
    .wdata_i    (wdata_i),
    .ovf_clr_i  (ovf_clr_i),
    .sec_o      (sec_o),
    .frac_o     (frac_o),
    .ovf_flag_o (ovf_flag_o),
    .at_max_o   (at_max)
  );

  rtc_alarm #(.SEC_W(SEC_W)) i_alarm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .alm_we_i   (alm_we_i),
    .wdata_i    (wdata_i),
    .sec_i      (sec_o),
    .alm_clr_i  (alm_clr_i),
    .alm_ie_i   (alm_ie_i),
    .alm_o      (alm_o),
    .alm_flag_o (alm_flag_o),
    .alm_irq_o  (alm_irq_o)
  );
endmodule

// File: rtl/rtc_sec_counter_chk.sv
module rtc_sec_counter_chk #(
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned FRAC_W = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              cnt_en_i,
  input logic              halt_i,
  input logic              lock_soft_i,
  input logic              lock_hard_i,
  input logic              sec_we_i,
  input logic              frac_we_i,
  input logic              alm_clr_i,
  input logic              ovf_clr_i,
  input logic [SEC_W-1:0]  sec_o,
  input logic [FRAC_W-1:0] frac_o,
  input logic [SEC_W-1:0]  alm_o,
  input logic              alm_flag_o,
  input logic              ovf_flag_o
);
  logic no_wr;
  assign no_wr = !sec_we_i && !frac_we_i;

  p_en_off_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_en_i && no_wr) |=> ($stable(sec_o) && $stable(frac_o)));

  p_halt_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_i && no_wr) |=> ($stable(sec_o) && $stable(frac_o)));

  p_lock_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((lock_soft_i || lock_hard_i) && !tick_i) |=> ($stable(sec_o) && $stable(frac_o)));

  p_alarm_match_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alm_flag_o) |-> ($past(sec_o) == $past(alm_o)));

  p_alarm_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(alm_flag_o) |-> $past(alm_clr_i));

  p_ovf_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_flag_o && no_wr) |=> ($stable(sec_o) && $stable(frac_o)));

  p_ovf_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovf_flag_o) |-> $past(ovf_clr_i));

  p_ovf_sat_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_flag_o) |-> ((&sec_o) && (&frac_o)));
endmodule

bind rtc_sec_counter rtc_sec_counter_chk #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .cnt_en_i    (cnt_en_i),
  .halt_i      (halt_i),
  .lock_soft_i (lock_soft_i),
  .lock_hard_i (lock_hard_i),
  .sec_we_i    (sec_we_i),
  .frac_we_i   (frac_we_i),
  .alm_clr_i   (alm_clr_i),
  .ovf_clr_i   (ovf_clr_i),
  .sec_o       (sec_o),
  .frac_o      (frac_o),
  .alm_o       (alm_o),
  .alm_flag_o  (alm_flag_o),
  .ovf_flag_o  (ovf_flag_o)
);

// File: tb/test_rtc_sec_counter.sv
`timescale 1ns/1ps
module test_rtc_sec_counter;
  localparam int SEL_SEC = 0, SEL_FRAC = 1, SEL_ALM = 2, SEL_AF = 3, SEL_OF = 4, SEL_IRQ = 5;

  typedef struct {
    string       tag;
    int          sel;
    logic [31:0] exp;
  } item_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 0, cnt_en_i = 0, halt_i = 0, lock_soft_i = 0, lock_hard_i = 0;
  logic        sec_we_i = 0, frac_we_i = 0, alm_we_i = 0, alm_clr_i = 0, ovf_clr_i = 0, alm_ie_i = 0;
  logic [31:0] wdata_i = '0;
  logic [31:0] sec_o, alm_o;
  logic [14:0] frac_o;
  logic        alm_flag_o, ovf_flag_o, alm_irq_o;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    done = 0;
  item_t sb_q[$];

  always #4 clk_i = ~clk_i;

  rtc_sec_counter i_rtc_sec_counter (
    .clk_i, .rst_ni, .tick_i, .cnt_en_i, .halt_i, .lock_soft_i, .lock_hard_i,
    .sec_we_i, .frac_we_i, .alm_we_i, .wdata_i, .alm_clr_i, .ovf_clr_i, .alm_ie_i,
    .sec_o, .frac_o, .alm_o, .alm_flag_o, .ovf_flag_o, .alm_irq_o
  );

  // monitor: compares queued expectations at the falling edge
  always @(negedge clk_i) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      case (it.sel)
        SEL_SEC:  act = sec_o;
        SEL_FRAC: act = {17'd0, frac_o};
        SEL_ALM:  act = alm_o;
        SEL_AF:   act = {31'd0, alm_flag_o};
        SEL_OF:   act = {31'd0, ovf_flag_o};
        default:  act = {31'd0, alm_irq_o};
      endcase
      n_checks++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_val(input string tag, input int sel, input logic [31:0] v);
    sb_q.push_back('{tag, sel, v});
  endtask

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic wr_sec(input logic [31:0] v);
    sec_we_i = 1; wdata_i = v; step(); sec_we_i = 0;
  endtask

  task automatic wr_frac(input logic [31:0] v);
    frac_we_i = 1; wdata_i = v; step(); frac_we_i = 0;
  endtask

  task automatic wr_alm(input logic [31:0] v);
    alm_we_i = 1; wdata_i = v; step(); alm_we_i = 0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick_i = 1; step(); tick_i = 0;
    end
  endtask

  task automatic settle();
    @(negedge clk_i); #1;
  endtask

  initial begin
    repeat (3) step();
    rst_ni = 1;
    step();
    expect_val("R1 sec", SEL_SEC, 32'd0);
    expect_val("R1 frac", SEL_FRAC, 32'd0);
    expect_val("R1 alarm", SEL_ALM, 32'hFFFF_FFFF);
    expect_val("R1 alarm flag", SEL_AF, 0);
    expect_val("R1 ovf flag", SEL_OF, 0);
    expect_val("R1 irq", SEL_IRQ, 0);
    settle();

    wr_sec(32'd5);
    wr_frac(32'hFFFF_0010);
    expect_val("R2 sec write", SEL_SEC, 32'd5);
    expect_val("R2 frac write", SEL_FRAC, 32'h10);
    settle();

    ticks(4);
    expect_val("R4 disabled frac", SEL_FRAC, 32'h10);
    expect_val("R4 disabled sec", SEL_SEC, 32'd5);
    settle();

    cnt_en_i = 1;
    ticks(3);
    expect_val("R3 count frac", SEL_FRAC, 32'h13);
    settle();

    wr_frac(32'h7FFF);
    ticks(1);
    expect_val("R3 carry sec", SEL_SEC, 32'd6);
    expect_val("R3 carry frac", SEL_FRAC, 32'd0);
    settle();

    halt_i = 1;
    ticks(5);
    halt_i = 0;
    expect_val("R5 halted frac", SEL_FRAC, 32'd0);
    expect_val("R5 halted sec", SEL_SEC, 32'd6);
    settle();

    lock_soft_i = 1; wr_sec(32'd100); lock_soft_i = 0;
    expect_val("R6 soft lock sec", SEL_SEC, 32'd6);
    settle();
    lock_hard_i = 1; wr_frac(32'h55); lock_hard_i = 0;
    expect_val("R6 hard lock frac", SEL_FRAC, 32'd0);
    settle();

    wr_alm(32'd7);
    expect_val("R7 alarm write", SEL_ALM, 32'd7);
    expect_val("R7 no early flag", SEL_AF, 0);
    settle();
    wr_frac(32'h7FFF);
    ticks(1);
    expect_val("R7 sec at alarm", SEL_SEC, 32'd7);
    expect_val("R7 flag one cycle late", SEL_AF, 0);
    settle();
    step();
    expect_val("R7 flag set", SEL_AF, 1);
    expect_val("R9 irq masked", SEL_IRQ, 0);
    settle();
    alm_ie_i = 1; #1;
    expect_val("R9 irq enabled", SEL_IRQ, 1);
    settle();

    alm_clr_i = 1; step(); alm_clr_i = 0;
    expect_val("R8 flag cleared", SEL_AF, 0);
    expect_val("R9 irq follows flag", SEL_IRQ, 0);
    settle();
    step(); step();
    expect_val("R8 no re-set on held match", SEL_AF, 0);
    settle();

    wr_alm(32'd20);
    wr_sec(32'd20);
    step();
    expect_val("R7 flag from write", SEL_AF, 1);
    settle();
    alm_clr_i = 1; step(); alm_clr_i = 0;
    alm_ie_i = 0;
    settle();

    wr_sec(32'hFFFF_FFFF);
    wr_frac(32'h7FFF);
    ticks(1);
    expect_val("R10 ovf flag", SEL_OF, 1);
    expect_val("R10 sec saturated", SEL_SEC, 32'hFFFF_FFFF);
    expect_val("R10 frac saturated", SEL_FRAC, 32'h7FFF);
    settle();
    ticks(3);
    expect_val("R10 stays at max", SEL_FRAC, 32'h7FFF);
    settle();

    wr_sec(32'd9);
    wr_frac(32'd0);
    ticks(2);
    expect_val("R11 write while ovf", SEL_SEC, 32'd9);
    expect_val("R11 held while ovf", SEL_FRAC, 32'd0);
    expect_val("R11 flag sticky", SEL_OF, 1);
    settle();
    ovf_clr_i = 1; step(); ovf_clr_i = 0;
    expect_val("R11 flag cleared", SEL_OF, 0);
    settle();
    ticks(1);
    expect_val("R11 resumed", SEL_FRAC, 32'd1);
    settle();

    sec_we_i = 1; tick_i = 1; wdata_i = 32'd40; step(); sec_we_i = 0; tick_i = 0;
    expect_val("R12 sec write wins", SEL_SEC, 32'd40);
    expect_val("R12 no increment", SEL_FRAC, 32'd1);
    settle();
    frac_we_i = 1; tick_i = 1; wdata_i = 32'h100; step(); frac_we_i = 0; tick_i = 0;
    expect_val("R12 frac write wins", SEL_FRAC, 32'h100);
    settle();

    step(); step();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule